// File: doc/BRIEF.md
# Keyed-Refresh Watchdog Timer

A down-counting watchdog whose counter lives in a slow timer clock domain while software programs it from a faster bus clock domain. Software sets a reload value and a refresh window, picks whether expiry should request a system reset or raise a sticky interrupt, and then sets an enable bit that also locks the configuration for good. To keep the system alive, software must write the 16-bit key 0xCCCC to the refresh register while the count sits inside the window. A wrong key or a refresh that comes too early triggers the expiry action at once.

Each bus write reaches the timer domain through its own toggle request/acknowledge handshake. A status register shows one busy flag per crossing channel, the lock state and the interrupt-pending flag. A hibernate input can freeze the count, depending on a control bit. In that case counting resumes from the held value once hibernate ends.

Register offsets: 0 control, 1 reload value, 2 window limit, 3 refresh (write-only), 4 status (read-only). Control fields: bit 0 freeze-in-hibernate (reset 1), bit 1 interrupt mode (reset 0), bit 5 enable-and-lock (reset 0). All other control bits are not stored and read 0. Status fields: bit 0 interrupt pending, bit 1 refresh crossing busy, bit 2 reload crossing busy, bit 3 control crossing busy, bit 4 locked, bit 6 window crossing busy. Bit 5 and bits 15:7 read 0.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, control reads 0x0001, reload reads 0x1000, window reads 0xFFFF, refresh reads 0, status reads 0, and both wdt_irq and wdt_reset_req are low.
- R2: Once enabled in reset mode, wdt_reset_req pulses high for one timer cycle. Consecutive pulses are exactly reload+1 counting timer cycles apart.
- R3: In interrupt mode (control bit 1 = 1), expiry sets wdt_irq and status bit 0 without any reset pulse. Both stay set until a valid refresh arrives.
- R4: Writing 0xCCCC to the refresh register while the count is at or below the window limit reloads the counter and clears the pending interrupt.
- R5: Writing any value other than 0xCCCC to the refresh register while enabled triggers the expiry action at once.
- R6: A 0xCCCC refresh that lands while the count is above the window limit is treated as a wrong key.
- R7: The refresh register always reads back 0.
- R8: With control bit 0 = 1, timer cycles in which hibernate is high neither decrement nor reload the count. With bit 0 = 0, hibernate has no effect on the interval.
- R9: A control write with bit 5 = 1 enables counting and sets status bit 4. From then on, writes to control, reload and window change nothing: read-back, busy flags and intervals all stay the same. Only bits 0, 1 and 5 of control are stored.
- R10: A write to control, reload, window or refresh sets status bit 3, 2, 6 or 1 respectively. That bit clears only after the value has taken effect in the timer domain.
- R11: A write to a register whose busy flag is set is dropped.
- R12: While bit 5 of control is clear, no refresh write (of any value) produces a reset pulse or an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for bus_addr |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst | input | 1 | Synchronous active-high reset, timer domain |
| hibernate | input | 1 | Hibernate indication, timer domain |
| wdt_irq | output | 1 | Pending expiry interrupt, timer domain |
| wdt_reset_req | output | 1 | One-cycle reset request, timer domain |

## Verification
Read data is registered, so a status read returns values from the edge before the sampled cycle. A busy flag is therefore already visible in the first read after the write. The timer side acts on the third timer edge after the bus accepts a write: two synchronizer flops, then the edge-detect strobe. The busy flag drops two bus edges after that. For this reason every check on a timer-side effect (reload, interrupt clear, wrong-key action) waits until the busy flag reads zero, and is made only then. The interrupt-pending status bit trails wdt_irq by two synchronizer stages plus the read register. Expiry intervals are counted at falling timer edges as the number of counting cycles between reset pulses, so the asynchronous crossing delays never enter the expected value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Register offsets on the bus side
  localparam int OFS_CTRL = 0;
  localparam int OFS_LOAD = 1;
  localparam int OFS_WIN  = 2;
  localparam int OFS_KICK = 3;
  localparam int OFS_STAT = 4;

  // Control field positions
  localparam int CTL_HIB = 0;
  localparam int CTL_IRQ = 1;
  localparam int CTL_EN  = 5;

  // Status field positions
  localparam int ST_IRQ  = 0;
  localparam int ST_KICK = 1;
  localparam int ST_LOAD = 2;
  localparam int ST_CTRL = 3;
  localparam int ST_LOCK = 4;
  localparam int ST_WIN  = 6;

  typedef struct packed {
    logic en;
    logic irq_mode;
    logic hib_stop;
  } wdt_ctl_t;

  localparam int CTL_W = $bits(wdt_ctl_t);
  localparam wdt_ctl_t CTL_RST = '{en: 1'b0, irq_mode: 1'b0, hib_stop: 1'b1};

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/wdt_xfer.sv
// Toggle request / acknowledge crossing for one register channel.
module wdt_xfer #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic             src_wr,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_busy,
  input  logic             dst_clk,
  input  logic             dst_rst,
  output logic             dst_vld,
  output logic [WIDTH-1:0] dst_data
);

  logic             req_q;
  logic [WIDTH-1:0] hold_q;
  logic             req_s;
  logic             seen_q;
  logic             ack_s;

  // Source side: capture data and flip the request, only when idle
  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (src_wr && !src_busy) begin
      req_q  <= ~req_q;
      hold_q <= src_data;
    end
  end

  wdt_sync #(.STAGES(STAGES), .WIDTH(1)) u_req_sync (
    .clk(dst_clk), .rst(dst_rst), .d(req_q), .q(req_s)
  );

  // Destination side: one-cycle strobe on every request flip
  always_ff @(posedge dst_clk) begin
    if (dst_rst) seen_q <= 1'b0;
    else         seen_q <= req_s;
  end

  assign dst_vld  = req_s ^ seen_q;
  assign dst_data = hold_q;

  wdt_sync #(.STAGES(STAGES), .WIDTH(1)) u_ack_sync (
    .clk(src_clk), .rst(src_rst), .d(seen_q), .q(ack_s)
  );

  assign src_busy = req_q ^ ack_s;

  assert_busy_after_write_R10: assert property (@(posedge src_clk) disable iff (src_rst)
    (src_wr && !src_busy) |=> src_busy);

  assert_hold_while_busy_R11: assert property (@(posedge src_clk) disable iff (src_rst)
    src_busy |=> $stable(hold_q));

  assert_single_strobe_R10: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_vld |=> !dst_vld);

endmodule

// File: rtl/wdt_core.sv
// Timer-domain counter, key check, window check and expiry action.
module wdt_core
  import wdt_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] LOAD_INIT = DATA_W'(16'h1000),
  parameter logic [DATA_W-1:0] KEY       = DATA_W'(16'hCCCC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hib,
  input  logic              kick_vld,
  input  logic [DATA_W-1:0] kick_data,
  input  logic              load_vld,
  input  logic [DATA_W-1:0] load_data,
  input  logic              win_vld,
  input  logic [DATA_W-1:0] win_data,
  input  logic              ctl_vld,
  input  wdt_ctl_t          ctl_data,
  output logic              irq,
  output logic              rst_req
);

  wdt_ctl_t          ctl_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] win_q;
  logic [DATA_W-1:0] cnt_q;
  logic              irq_q;
  logic              rreq_q;

  logic run, kick_en, key_ok, in_win, kick_good, kick_bad, expire, fault;

  always_comb begin
    run       = ctl_q.en && !(hib && ctl_q.hib_stop);
    kick_en   = kick_vld && ctl_q.en;
    key_ok    = (kick_data == KEY);
    in_win    = (cnt_q <= win_q);
    kick_good = kick_en && key_ok && in_win;
    kick_bad  = kick_en && !(key_ok && in_win);
    expire    = run && (cnt_q == '0);
    fault     = kick_bad || (expire && !kick_good);
  end

  // Configuration, updated by the crossing strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_RST;
      load_q <= LOAD_INIT;
      win_q  <= '1;
    end else begin
      if (ctl_vld)  ctl_q  <= ctl_data;
      if (load_vld) load_q <= load_data;
      if (win_vld)  win_q  <= win_data;
    end
  end

  // Counter
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= LOAD_INIT;
    end else if (!ctl_q.en) begin
      cnt_q <= load_q;
    end else if (kick_good || fault) begin
      cnt_q <= load_q;
    end else if (run) begin
      cnt_q <= cnt_q - DATA_W'(1);
    end
  end

  // Expiry action
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      rreq_q <= fault && !ctl_q.irq_mode;
      if (fault && ctl_q.irq_mode) irq_q <= 1'b1;
      else if (kick_good)          irq_q <= 1'b0;
    end
  end

  assign irq     = irq_q;
  assign rst_req = rreq_q;

  assert_no_early_reset_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.en && cnt_q != '0 && !kick_vld) |=> !rreq_q);

  assert_irq_rise_mode_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(ctl_q.irq_mode));

  assert_irq_clear_key_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_q) |-> ($past(kick_vld) && $past(kick_data) == KEY));

  assert_bad_key_acts_R5: assert property (@(posedge clk) disable iff (rst)
    (kick_vld && ctl_q.en && kick_data != KEY) |=> (irq_q || rreq_q));

  assert_early_kick_acts_R6: assert property (@(posedge clk) disable iff (rst)
    (kick_vld && ctl_q.en && cnt_q > win_q) |=> (irq_q || rreq_q));

  assert_hib_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.en && ctl_q.hib_stop && hib && !kick_vld) |=> $stable(cnt_q));

  assert_enable_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_q.en |=> ctl_q.en);

  assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.en |=> (!rreq_q && !$rose(irq_q)));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                ADDR_W      = 3,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] LOAD_INIT   = DATA_W'(16'h1000),
  parameter logic [DATA_W-1:0] KEY         = DATA_W'(16'hCCCC)
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmr_clk,
  input  logic              tmr_rst,
  input  logic              hibernate,
  output logic              wdt_irq,
  output logic              wdt_reset_req
);

  // Bus-side state
  logic              lock_q;
  wdt_ctl_t          ctl_sh;
  logic [DATA_W-1:0] load_sh;
  logic [DATA_W-1:0] win_sh;
  wdt_ctl_t          ctl_in;

  logic wr_ctrl, wr_load, wr_win, wr_kick;
  logic busy_ctrl, busy_load, busy_win, busy_kick;
  logic irq_s;

  // Timer-side strobes
  logic              t_ctl_vld, t_load_vld, t_win_vld, t_kick_vld;
  wdt_ctl_t          t_ctl;
  logic [DATA_W-1:0] t_load, t_win, t_kick;

  always_comb begin
    ctl_in.en       = bus_wdata[CTL_EN];
    ctl_in.irq_mode = bus_wdata[CTL_IRQ];
    ctl_in.hib_stop = bus_wdata[CTL_HIB];
    wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && !lock_q;
    wr_load = bus_wr && (bus_addr == ADDR_W'(OFS_LOAD)) && !lock_q;
    wr_win  = bus_wr && (bus_addr == ADDR_W'(OFS_WIN))  && !lock_q;
    wr_kick = bus_wr && (bus_addr == ADDR_W'(OFS_KICK));
  end

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      lock_q  <= 1'b0;
      ctl_sh  <= CTL_RST;
      load_sh <= LOAD_INIT;
      win_sh  <= '1;
    end else begin
      if (wr_ctrl && !busy_ctrl) begin
        ctl_sh <= ctl_in;
        if (ctl_in.en) lock_q <= 1'b1;
      end
      if (wr_load && !busy_load) load_sh <= bus_wdata;
      if (wr_win  && !busy_win)  win_sh  <= bus_wdata;
    end
  end

  // One crossing per register
  wdt_xfer #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_x_ctrl (
    .src_clk(bus_clk), .src_rst(bus_rst), .src_wr(wr_ctrl), .src_data(ctl_in),
    .src_busy(busy_ctrl), .dst_clk(tmr_clk), .dst_rst(tmr_rst),
    .dst_vld(t_ctl_vld), .dst_data(t_ctl)
  );

  wdt_xfer #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_x_load (
    .src_clk(bus_clk), .src_rst(bus_rst), .src_wr(wr_load), .src_data(bus_wdata),
    .src_busy(busy_load), .dst_clk(tmr_clk), .dst_rst(tmr_rst),
    .dst_vld(t_load_vld), .dst_data(t_load)
  );

  wdt_xfer #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_x_win (
    .src_clk(bus_clk), .src_rst(bus_rst), .src_wr(wr_win), .src_data(bus_wdata),
    .src_busy(busy_win), .dst_clk(tmr_clk), .dst_rst(tmr_rst),
    .dst_vld(t_win_vld), .dst_data(t_win)
  );

  wdt_xfer #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_x_kick (
    .src_clk(bus_clk), .src_rst(bus_rst), .src_wr(wr_kick), .src_data(bus_wdata),
    .src_busy(busy_kick), .dst_clk(tmr_clk), .dst_rst(tmr_rst),
    .dst_vld(t_kick_vld), .dst_data(t_kick)
  );

  wdt_core #(.DATA_W(DATA_W), .LOAD_INIT(LOAD_INIT), .KEY(KEY)) u_core (
    .clk(tmr_clk), .rst(tmr_rst), .hib(hibernate),
    .kick_vld(t_kick_vld), .kick_data(t_kick),
    .load_vld(t_load_vld), .load_data(t_load),
    .win_vld(t_win_vld),   .win_data(t_win),
    .ctl_vld(t_ctl_vld),   .ctl_data(t_ctl),
    .irq(wdt_irq), .rst_req(wdt_reset_req)
  );

  wdt_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_irq_sync (
    .clk(bus_clk), .rst(bus_rst), .d(wdt_irq), .q(irq_s)
  );

  // Registered read data
  logic [DATA_W-1:0] rd_ctl, rd_stat;

  always_comb begin
    rd_ctl          = '0;
    rd_ctl[CTL_EN]  = ctl_sh.en;
    rd_ctl[CTL_IRQ] = ctl_sh.irq_mode;
    rd_ctl[CTL_HIB] = ctl_sh.hib_stop;
    rd_stat          = '0;
    rd_stat[ST_IRQ]  = irq_s;
    rd_stat[ST_KICK] = busy_kick;
    rd_stat[ST_LOAD] = busy_load;
    rd_stat[ST_CTRL] = busy_ctrl;
    rd_stat[ST_LOCK] = lock_q;
    rd_stat[ST_WIN]  = busy_win;
  end

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_W'(OFS_CTRL): bus_rdata <= rd_ctl;
        ADDR_W'(OFS_LOAD): bus_rdata <= load_sh;
        ADDR_W'(OFS_WIN):  bus_rdata <= win_sh;
        ADDR_W'(OFS_STAT): bus_rdata <= rd_stat;
        default:           bus_rdata <= '0;
      endcase
    end
  end

  assert_lock_sticky_R9: assert property (@(posedge bus_clk) disable iff (bus_rst)
    lock_q |=> lock_q);

  assert_locked_load_R9: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (lock_q && bus_wr && bus_addr == ADDR_W'(OFS_LOAD)) |=> $stable(load_sh));

  assert_locked_no_busy_R9: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (lock_q && !busy_load && !busy_win) |=> (!busy_load && !busy_win));

  assert_busy_drop_R11: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (busy_win && bus_wr && bus_addr == ADDR_W'(OFS_WIN)) |=> $stable(win_sh));

endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int A_CTRL = 0, A_LOAD = 1, A_WIN = 2, A_KICK = 3, A_STAT = 4;
  localparam logic [DW-1:0] KEY = 16'hCCCC;
  localparam logic [DW-1:0] BUSY_MASK = 16'h004E;

  logic bus_clk = 1'b0;
  logic tmr_clk = 1'b0;
  always #10 bus_clk = ~bus_clk;
  always #85 tmr_clk = ~tmr_clk;

  logic          bus_rst = 1'b1;
  logic          tmr_rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          hib = 1'b0;
  logic          wdt_irq, wdt_reset_req;

  keyed_watchdog u_keyed_watchdog (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_clk(tmr_clk), .tmr_rst(tmr_rst),
    .hibernate(hib), .wdt_irq(wdt_irq), .wdt_reset_req(wdt_reset_req)
  );

  int checks = 0;
  int errors = 0;

  // Timer-domain monitor: counts counting cycles between reset pulses
  int acnt = 0, npulse = 0, last_iv = 0;
  bit stop_cfg = 1'b0;
  int hib_pct = 0;

  always @(negedge tmr_clk) begin
    if (tmr_rst) begin
      acnt = 0; npulse = 0; last_iv = 0;
    end else begin
      if (!(hib && stop_cfg)) acnt++;
      if (wdt_reset_req) begin
        last_iv = acnt; acnt = 0; npulse++;
      end
    end
    hib = (int'($urandom % 100) < hib_pct);
  end

  function automatic int exp_interval(input int load_v);
    return load_v + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic apply_reset();
    bus_rst = 1'b1; tmr_rst = 1'b1;
    repeat (4) @(posedge tmr_clk);
    #2 tmr_rst = 1'b0;
    @(negedge bus_clk) bus_rst = 1'b0;
    repeat (2) @(negedge bus_clk);
  endtask

  task automatic bus_write(input int a, input logic [DW-1:0] d);
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [DW-1:0] v);
    @(negedge bus_clk) bus_addr = AW'(a);
    @(negedge bus_clk) v = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [DW-1:0] s;
    bit done = 1'b0;
    for (int i = 0; i < 300 && !done; i++) begin
      bus_read(A_STAT, s);
      if ((s & BUSY_MASK) == '0) done = 1'b1;
    end
    check(done, req, int'(s & BUSY_MASK), 0);
  endtask

  task automatic tmr_wait(input int n);
    repeat (n) @(posedge tmr_clk);
    #1;
  endtask

  task automatic wait_pulse(input string req, input int maxc);
    int p = npulse;
    bit got = 1'b0;
    for (int i = 0; i < maxc && !got; i++) begin
      @(posedge tmr_clk); #1;
      if (npulse > p) got = 1'b1;
    end
    check(got, req, npulse, p + 1);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int p;
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED_0042);

    // ---------------- R1: reset state
    stop_cfg = 1'b0; hib_pct = 0;
    apply_reset();
    bus_read(A_CTRL, v); check(v == 16'h0001, "R1 ctrl", v, 16'h0001);
    bus_read(A_LOAD, v); check(v == 16'h1000, "R1 load", v, 16'h1000);
    bus_read(A_WIN, v);  check(v == 16'hFFFF, "R1 win", v, 16'hFFFF);
    bus_read(A_KICK, v); check(v == 16'h0000, "R1 kick", v, 0);
    bus_read(A_STAT, v); check(v == 16'h0000, "R1 stat", v, 0);
    check(!wdt_irq && !wdt_reset_req, "R1 outputs", {wdt_irq, wdt_reset_req}, 0);

    // ---------------- R10: busy flags per register
    bus_write(A_LOAD, 16'd30);
    bus_read(A_STAT, v); check(v == 16'h0004, "R10 load busy", v, 16'h0004);
    wait_idle("R10 load idle");
    bus_read(A_LOAD, v); check(v == 16'd30, "R10 load value", v, 30);
    bus_write(A_WIN, 16'hFFFF);
    bus_read(A_STAT, v); check(v == 16'h0040, "R10 win busy", v, 16'h0040);
    wait_idle("R10 win idle");
    bus_write(A_CTRL, 16'h0000);
    bus_read(A_STAT, v); check(v == 16'h0008, "R10 ctrl busy", v, 16'h0008);
    wait_idle("R10 ctrl idle");
    bus_write(A_KICK, 16'h1234);
    bus_read(A_STAT, v); check(v == 16'h0002, "R10 kick busy", v, 16'h0002);
    wait_idle("R10 kick idle");

    // ---------------- R11: write during busy is dropped
    bus_write(A_LOAD, 16'd18);
    bus_write(A_LOAD, 16'd77);
    wait_idle("R11 idle");
    bus_read(A_LOAD, v); check(v == 16'd18, "R11 dropped write", v, 18);

    // ---------------- R12: disabled timer ignores refresh writes
    bus_write(A_KICK, 16'h4321);
    wait_idle("R12 idle");
    tmr_wait(60);
    check(npulse == 0, "R12 no reset pulse", npulse, 0);
    check(!wdt_irq, "R12 no interrupt", wdt_irq, 0);

    // ---------------- R9 enable, lock, ctrl masking; R8 stop clear
    hib_pct = 50;
    bus_write(A_CTRL, 16'hFFFC);
    bus_read(A_STAT, v); check(v[4] == 1'b1, "R9 lock bit", v, 16'h0018);
    wait_idle("R9 idle");
    bus_read(A_STAT, v); check(v == 16'h0010, "R9 stat locked", v, 16'h0010);
    bus_read(A_CTRL, v); check(v == 16'h0020, "R9 ctrl stored bits", v, 16'h0020);
    wait_pulse("R2 first pulse", 200);
    wait_pulse("R2 pulse", 200);
    check(last_iv == exp_interval(18), "R2 interval", last_iv, exp_interval(18));
    wait_pulse("R8 pulse", 200);
    check(last_iv == exp_interval(18), "R8 no freeze when bit0 clear", last_iv, exp_interval(18));

    bus_write(A_LOAD, 16'd5);
    bus_read(A_STAT, v); check(v == 16'h0010, "R9 locked write no busy", v, 16'h0010);
    bus_read(A_LOAD, v); check(v == 16'd18, "R9 load unchanged", v, 18);
    bus_write(A_CTRL, 16'h0003);
    bus_read(A_CTRL, v); check(v == 16'h0020, "R9 ctrl unchanged", v, 16'h0020);
    wait_pulse("R9 pulse", 200);
    wait_pulse("R9 pulse", 200);
    check(last_iv == exp_interval(18), "R9 interval unchanged", last_iv, exp_interval(18));

    // ---------------- R7: refresh reads zero
    bus_write(A_KICK, KEY);
    bus_read(A_KICK, v); check(v == 16'h0000, "R7 kick reads zero", v, 0);
    wait_idle("R7 idle");

    // ---------------- R5: wrong key acts at once
    hib_pct = 0;
    wait_pulse("R5 sync pulse", 200);
    p = npulse;
    bus_write(A_KICK, 16'h5555);
    wait_idle("R5 idle");
    tmr_wait(2);
    check(npulse == p + 1, "R5 immediate pulse", npulse, p + 1);
    check(last_iv < 12, "R5 short interval", last_iv, 12);

    // ---------------- R6 early refresh, R4 in-window refresh
    stop_cfg = 1'b0; hib_pct = 0;
    apply_reset();
    bus_write(A_LOAD, 16'd40); wait_idle("R6 load");
    bus_write(A_WIN, 16'd10);  wait_idle("R6 win");
    bus_write(A_CTRL, 16'h0020); wait_idle("R6 ctrl");
    wait_pulse("R6 sync pulse", 200);
    p = npulse;
    bus_write(A_KICK, KEY);
    wait_idle("R6 idle");
    tmr_wait(2);
    check(npulse == p + 1, "R6 early key pulse", npulse, p + 1);
    check(last_iv < 15, "R6 short interval", last_iv, 15);
    p = npulse;
    tmr_wait(28);
    bus_write(A_KICK, KEY);
    wait_idle("R4 idle");
    check(npulse == p, "R4 no pulse on good key", npulse, p);
    wait_pulse("R4 next pulse", 200);
    check(npulse == p + 1, "R4 single pulse", npulse, p + 1);
    check(last_iv >= 65 && last_iv <= 85, "R4 reload extends interval", last_iv, 75);

    // ---------------- R3 interrupt mode, R4 clear, R5 wrong key in irq mode
    apply_reset();
    bus_write(A_LOAD, 16'd25);   wait_idle("R3 load");
    bus_write(A_CTRL, 16'h0022); wait_idle("R3 ctrl");
    tmr_wait(40);
    check(wdt_irq == 1'b1, "R3 irq set", wdt_irq, 1);
    check(npulse == 0, "R3 no reset pulse", npulse, 0);
    bus_read(A_STAT, v); check(v == 16'h0011, "R3 stat irq", v, 16'h0011);
    tmr_wait(60);
    check(wdt_irq == 1'b1, "R3 irq sticky", wdt_irq, 1);
    bus_write(A_KICK, KEY);
    wait_idle("R4 clear idle");
    check(wdt_irq == 1'b0, "R4 irq cleared", wdt_irq, 0);
    tmr_wait(1);
    bus_read(A_STAT, v); check(v == 16'h0010, "R4 stat cleared", v, 16'h0010);
    bus_write(A_KICK, 16'h0000);
    wait_idle("R5 irq idle");
    check(wdt_irq == 1'b1, "R5 wrong key irq", wdt_irq, 1);
    check(npulse == 0, "R5 irq mode no reset", npulse, 0);

    // ---------------- R8 / R2 random: reload, freeze bit and hibernate density
    for (int run = 0; run < 5; run++) begin
      int ld, pct;
      bit stp;
      ld  = 6 + int'($urandom % 30);
      stp = 1'($urandom % 2);
      pct = 20 + int'($urandom % 50);
      stop_cfg = stp; hib_pct = 0;
      apply_reset();
      bus_write(A_LOAD, DW'(ld)); wait_idle("R8 load");
      bus_write(A_CTRL, {10'd0, 1'b1, 4'd0, stp}); wait_idle("R8 ctrl");
      hib_pct = pct;
      wait_pulse("R8 first pulse", 500);
      for (int k = 0; k < 2; k++) begin
        wait_pulse("R8 pulse", 500);
        check(last_iv == exp_interval(ld), "R8 counting cycles per interval",
              last_iv, exp_interval(ld));
      end
    end
    hib_pct = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule